// File: doc/BRIEF.md
# HDLC-like transmit frame encapsulator

This block turns packets into an octet-synchronous, HDLC-like byte stream for a SONET/SDH payload mapper. Packet bytes, with the frame check sequence already appended by an upstream stage, arrive from a FIFO-style source. Each byte comes with a valid/ready handshake and with start and end markers. The line side pulls one byte per cycle by raising a request. Each request is answered one cycle later by exactly one output byte.

Frames are delimited by 0x7E flag octets, and the idle line is filled with flags. Any frame byte that equals the flag or the escape value (0x7D) is sent as 0x7D followed by the byte XORed with 0x20. This costs one extra output cycle, and the source is held off for that cycle. A mode input sets the minimum spacing between consecutive frames to one flag or to two flags. With one flag, a single flag closes one frame and opens the next. If the source runs dry in the middle of a frame, the block aborts the frame by sending 0x7D 0x7E. It then discards the rest of that packet up to its end marker, and restarts with the next packet once the flag spacing is met. Scrambling, check-sequence generation and overhead insertion are done elsewhere.

Top module: `hdlc_tx_encap`

## Requirements
- R1: A frame byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XORed with 0x20. No other frame byte is altered, and no raw 0x7E or 0x7D appears inside a frame.
- R2: While no frame is being sent, every requested output byte is the flag 0x7E.
- R3: With `twoFlags` low, at least one flag separates the last byte of a frame from the first byte of the next. When the source is ready without pause, exactly one flag separates them, so one flag is shared as closing and opening flag.
- R4: With `twoFlags` high, at least two flags separate consecutive frames, including the case after an abort. When the source is ready without pause, exactly two flags separate them.
- R5: If `lineReq` is high inside a frame while `srcValid` is low and no escaped second byte is pending, the next two output bytes are 0x7D then 0x7E.
- R6: After an abort, the source is accepted every cycle and its bytes are discarded up to and including the one marked `srcEof`. The next packet is then sent intact. The abort's 0x7E counts as one flag of the gap.
- R7: While the second byte of an escape pair is sent, `srcReady` is low, so each escaped byte stalls the source for one request cycle.
- R8: `lineValid` is high in the cycle after each cycle in which `lineReq` was high, and low otherwise. Each such cycle carries exactly one output byte, and the stream does not advance without a request.
- R9: During reset, `lineValid` is low, `lineData` is 0x7E and `srcReady` is low.
- R10: A frame starts only with a byte marked `srcSof`. Its bytes go out in source order, and the frame ends after the byte marked `srcEof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| twoFlags | input | 1 | 1: at least two flags between frames; 0: at least one |
| srcValid | input | 1 | Source byte available |
| srcData | input | 8 | Source byte (packet data or check sequence) |
| srcSof | input | 1 | Marks the first byte of a packet |
| srcEof | input | 1 | Marks the last byte of a packet |
| srcReady | output | 1 | Source byte is taken at this clock edge when valid |
| lineReq | input | 1 | Line side requests one byte at this edge |
| lineValid | output | 1 | `lineData` carries the byte for the previous request |
| lineData | output | 8 | Encapsulated output byte |

## Verification
A request sampled at a rising edge is answered by `lineData` and `lineValid` right after that edge. The second byte of an escape pair follows on the next request, and an abort pair fills the two requests that start with the cycle in which the source was found empty. The bench drives inputs and samples outputs on the falling edge. It records every byte flagged by `lineValid` and compares the count with the requests it issued. It then decodes the recorded stream offline into frames, flag gaps and abort marks, so the checks do not depend on guessing the cycle in which a frame begins. Where a result has a fixed place in the stream, such as the bytes right after the last good byte before an abort, the bench checks that exact position.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int OCTET_W = 8;
  localparam logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [OCTET_W-1:0] ESC_OCTET  = 8'h7D;
  localparam logic [OCTET_W-1:0] ESC_MASK   = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_SECOND,
    ST_ABORT,
    ST_DRAIN
  } txState_e;

  typedef struct packed {
    logic emitFlag;
    logic emitEscape;
    logic emitData;
    logic emitHeld;
    logic captureHeld;
  } txStrobe_t;
endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int MAX_FLAG_GAP = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      twoFlags,
  input  logic      lineReq,
  input  logic      srcValid,
  input  logic      srcSof,
  input  logic      srcEof,
  input  logic      isSpecial,
  output logic      srcReady,
  output txStrobe_t stb
);
  localparam int CNT_W = $clog2(MAX_FLAG_GAP + 1);

  txState_e         state, nextState;
  logic [CNT_W-1:0] flagCnt, nextCnt, bumpCnt, needCnt;
  logic             heldEof, nextHeldEof;
  logic             flagOk, acceptByte;

  assign needCnt = twoFlags ? CNT_W'(MAX_FLAG_GAP) : CNT_W'(1);
  assign flagOk  = flagCnt >= needCnt;
  assign bumpCnt = (flagCnt == CNT_W'(MAX_FLAG_GAP)) ? flagCnt : flagCnt + CNT_W'(1);

  always_comb begin
    nextState   = state;
    nextCnt     = flagCnt;
    nextHeldEof = heldEof;
    stb         = '0;
    srcReady    = 1'b0;
    acceptByte  = 1'b0;
    case (state)
      ST_IDLE: begin
        srcReady = lineReq && srcSof && flagOk;
        if (lineReq) begin
          if (srcValid && srcSof && flagOk) begin
            acceptByte = 1'b1;
          end else begin
            stb.emitFlag = 1'b1;
            nextCnt      = bumpCnt;
          end
        end
      end
      ST_BODY: begin
        srcReady = lineReq;
        if (lineReq) begin
          if (srcValid) begin
            acceptByte = 1'b1;
          end else begin
            stb.emitEscape = 1'b1;
            nextState      = ST_ABORT;
          end
        end
      end
      ST_SECOND: begin
        if (lineReq) begin
          stb.emitHeld = 1'b1;
          nextState    = heldEof ? ST_IDLE : ST_BODY;
        end
      end
      ST_ABORT: begin
        if (lineReq) begin
          stb.emitFlag = 1'b1;
          nextCnt      = CNT_W'(1);
          nextState    = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        srcReady = 1'b1;
        if (lineReq) begin
          stb.emitFlag = 1'b1;
          nextCnt      = bumpCnt;
        end
        if (srcValid && srcEof) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase

    if (acceptByte) begin
      nextCnt = '0;
      if (isSpecial) begin
        stb.emitEscape  = 1'b1;
        stb.captureHeld = 1'b1;
        nextHeldEof     = srcEof;
        nextState       = ST_SECOND;
      end else begin
        stb.emitData = 1'b1;
        nextState    = srcEof ? ST_IDLE : ST_BODY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      flagCnt <= '0;
      heldEof <= 1'b0;
    end else begin
      state   <= nextState;
      flagCnt <= nextCnt;
      heldEof <= nextHeldEof;
    end
  end

  AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> (stb.emitFlag || stb.emitEscape || stb.emitData || stb.emitHeld)); // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.emitFlag, stb.emitEscape, stb.emitData, stb.emitHeld})); // R8
  AST_HELD_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitHeld |-> !srcReady); // R7
endmodule

// File: rtl/hdlc_tx_dpath.sv
module hdlc_tx_dpath
  import hdlc_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          stb,
  input  logic [OCTET_W-1:0] srcData,
  input  logic               lineReq,
  output logic               isSpecial,
  output logic               lineValid,
  output logic [OCTET_W-1:0] lineData
);
  logic [OCTET_W-1:0] heldByte;

  assign isSpecial = (srcData == FLAG_OCTET) || (srcData == ESC_OCTET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineData  <= FLAG_OCTET;
      lineValid <= 1'b0;
      heldByte  <= '0;
    end else begin
      lineValid <= lineReq;
      if (stb.captureHeld) heldByte <= srcData ^ ESC_MASK;
      if (stb.emitFlag)        lineData <= FLAG_OCTET;
      else if (stb.emitEscape) lineData <= ESC_OCTET;
      else if (stb.emitData)   lineData <= srcData;
      else if (stb.emitHeld)   lineData <= heldByte;
    end
  end

  AST_NO_RAW_SPECIAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitData |-> !isSpecial); // R1
  AST_HELD_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitHeld |-> ((heldByte == (FLAG_OCTET ^ ESC_MASK)) || (heldByte == (ESC_OCTET ^ ESC_MASK)))); // R1
endmodule

// File: rtl/hdlc_tx_encap.sv
module hdlc_tx_encap
  import hdlc_tx_pkg::*;
#(
  parameter int MAX_FLAG_GAP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       twoFlags,
  input  logic       srcValid,
  input  logic [7:0] srcData,
  input  logic       srcSof,
  input  logic       srcEof,
  output logic       srcReady,
  input  logic       lineReq,
  output logic       lineValid,
  output logic [7:0] lineData
);
  txStrobe_t stb;
  logic      isSpecial;

  hdlc_tx_ctrl #(.MAX_FLAG_GAP(MAX_FLAG_GAP)) ctrl_i (
    .clk(clk), .rstN(rstN), .twoFlags(twoFlags), .lineReq(lineReq),
    .srcValid(srcValid), .srcSof(srcSof), .srcEof(srcEof),
    .isSpecial(isSpecial), .srcReady(srcReady), .stb(stb)
  );

  hdlc_tx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .srcData(srcData), .lineReq(lineReq),
    .isSpecial(isSpecial), .lineValid(lineValid), .lineData(lineData)
  );
endmodule

// File: tb/hdlc_tx_encap_tb_top.sv
module hdlc_tx_encap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic       twoFlags = 0;
  logic       srcValid = 0;
  logic [7:0] srcData = 0;
  logic       srcSof = 0;
  logic       srcEof = 0;
  logic       srcReady;
  logic       lineReq = 0;
  logic       lineValid;
  logic [7:0] lineData;

  hdlc_tx_encap dut_i (
    .clk(clk), .rstN(rstN), .twoFlags(twoFlags), .srcValid(srcValid),
    .srcData(srcData), .srcSof(srcSof), .srcEof(srcEof), .srcReady(srcReady),
    .lineReq(lineReq), .lineValid(lineValid), .lineData(lineData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  bit reqOn = 0, reqToggle = 0, capOn = 0;
  int reqCount = 0;
  logic [7:0] cap[$];

  always @(negedge clk) begin
    logic nx;
    nx = reqOn ? (reqToggle ? !lineReq : 1'b1) : 1'b0;
    lineReq <= nx;
    if (nx) reqCount++;
    if (capOn && lineValid) cap.push_back(lineData);
  end

  logic [7:0] bufA[0:63], bufB[0:63], txBuf[0:63];
  int lenA, lenB, txLen, holeAt = -1, holeLen = 0, lastStalls;

  int nFrames, decLen[0:7], decGap[0:7];
  bit decAbort[0:7];
  logic [7:0] decBuf[0:7][0:63];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushFrame();
    int i = 0;
    bit started = 0, holeDone = 0, acc;
    lastStalls = 0;
    while (i < txLen) begin
      if (i == holeAt && !holeDone) begin
        srcValid = 0; srcSof = 0; srcEof = 0;
        repeat (holeLen) @(negedge clk);
        holeDone = 1;
      end
      srcValid = 1; srcData = txBuf[i]; srcSof = (i == 0); srcEof = (i == txLen - 1);
      #1 acc = srcReady;
      @(negedge clk);
      if (acc) begin i++; started = 1; end
      else if (started) lastStalls++;
    end
    srcValid = 0; srcSof = 0; srcEof = 0;
  endtask

  task automatic startCap();
    @(posedge clk);
    cap.delete(); reqCount = 0; capOn = 1; reqOn = 1;
    @(negedge clk);
  endtask

  task automatic stopCap();
    repeat (4) @(negedge clk);
    @(posedge clk); reqOn = 0;
    repeat (3) @(posedge clk);
    capOn = 0;
    decodeCap();
  endtask

  task automatic decodeCap();
    int gap = 0;
    bit inFrame = 0, esc = 0;
    logic [7:0] b;
    nFrames = 0;
    for (int k = 0; k < cap.size(); k++) begin
      b = cap[k];
      if (!inFrame) begin
        if (b == 8'h7E) begin gap++; continue; end
        if (nFrames > 7) continue;
        inFrame = 1; decGap[nFrames] = gap; decLen[nFrames] = 0; decAbort[nFrames] = 0;
      end
      if (esc) begin
        esc = 0;
        if (b == 8'h7E) begin
          decAbort[nFrames] = 1; nFrames++; inFrame = 0; gap = 1;
        end else if (decLen[nFrames] < 64) begin
          decBuf[nFrames][decLen[nFrames]] = b ^ 8'h20; decLen[nFrames]++;
        end
      end else if (b == 8'h7D) esc = 1;
      else if (b == 8'h7E) begin nFrames++; inFrame = 0; gap = 1; end
      else if (decLen[nFrames] < 64) begin
        decBuf[nFrames][decLen[nFrames]] = b; decLen[nFrames]++;
      end
    end
  endtask

  task automatic checkFrame(input int idx, input bit useB, input string req);
    int len = useB ? lenB : lenA;
    bit ok = (decLen[idx] == len) && !decAbort[idx];
    for (int i = 0; i < len && i < 64; i++)
      if (decBuf[idx][i] != (useB ? bufB[i] : bufA[i])) ok = 0;
    check(ok, req, decLen[idx], len);
  endtask

  task automatic fillPlain(input logic [7:0] baseA, input int la, input logic [7:0] baseB, input int lb);
    lenA = la; lenB = lb;
    for (int i = 0; i < 64; i++) begin
      bufA[i] = baseA + 8'(i); bufB[i] = baseB + 8'(i);
    end
  endtask

  task automatic testReset();
    check(lineValid == 0, "R9 lineValid", lineValid, 0);
    check(lineData == 8'h7E, "R9 lineData", lineData, 8'h7E);
    check(srcReady == 0, "R9 srcReady", srcReady, 0);
  endtask

  task automatic testIdle();
    bit allFlags = 1;
    startCap();
    repeat (12) @(negedge clk);
    stopCap();
    foreach (cap[k]) if (cap[k] != 8'h7E) allFlags = 0;
    check(allFlags && cap.size() > 0, "R2 idle fill", cap.size(), 12);
    check(cap.size() == reqCount, "R8 one byte per request", cap.size(), reqCount);
  endtask

  task automatic testEscape();
    logic [7:0] expRaw[0:8] = '{8'h11, 8'h7D, 8'h5E, 8'h22, 8'h7D, 8'h5D, 8'h33, 8'h5D, 8'h5E};
    logic [7:0] raw[$];
    bit ok;
    twoFlags = 0;
    bufA[0] = 8'h11; bufA[1] = 8'h7E; bufA[2] = 8'h22; bufA[3] = 8'h7D;
    bufA[4] = 8'h33; bufA[5] = 8'h5D; bufA[6] = 8'h5E; lenA = 7;
    startCap();
    txBuf = bufA; txLen = lenA; holeAt = -1;
    pushFrame();
    stopCap();
    foreach (cap[k]) if (cap[k] != 8'h7E) raw.push_back(cap[k]);
    ok = (raw.size() == 9);
    for (int i = 0; i < 9 && i < raw.size(); i++) if (raw[i] != expRaw[i]) ok = 0;
    check(ok, "R1 stuffed bytes", raw.size(), 9);
    check(nFrames == 1, "R10 frame count", nFrames, 1);
    checkFrame(0, 0, "R10 content after unstuffing");
    check(lastStalls == 2, "R7 one stall per escape", lastStalls, 2);
  endtask

  task automatic testBackToBack(input bit two);
    twoFlags = two;
    fillPlain(8'h40, 5, 8'h60, 5);
    startCap();
    holeAt = -1;
    txBuf = bufA; txLen = lenA; pushFrame();
    txBuf = bufB; txLen = lenB; pushFrame();
    stopCap();
    check(nFrames == 2, two ? "R4 frame count" : "R3 frame count", nFrames, 2);
    checkFrame(0, 0, "R10 first frame");
    checkFrame(1, 1, "R10 second frame");
    if (two) check(decGap[1] == 2, "R4 two-flag gap", decGap[1], 2);
    else     check(decGap[1] == 1, "R3 shared flag gap", decGap[1], 1);
    twoFlags = 0;
  endtask

  task automatic testAbort(input bit two);
    int pos = -1;
    bit seqOk;
    twoFlags = two;
    fillPlain(8'hA0, 8, 8'hB0, 4);
    startCap();
    txBuf = bufA; txLen = lenA; holeAt = 3; holeLen = 3; pushFrame();
    holeAt = -1;
    txBuf = bufB; txLen = lenB; pushFrame();
    stopCap();
    foreach (cap[k]) if (cap[k] == 8'hA2 && pos < 0) pos = k;
    seqOk = (pos >= 0) && (pos + 2 < cap.size()) && (cap[pos+1] == 8'h7D) && (cap[pos+2] == 8'h7E);
    check(seqOk, "R5 abort pair follows last good byte", pos, 1);
    check(nFrames == 2 && decAbort[0] && decLen[0] == 3, "R5 aborted frame", decLen[0], 3);
    checkFrame(1, 1, "R6 next frame intact");
    if (two) check(decGap[1] >= 2, "R4 gap after abort", decGap[1], 2);
    else     check(decGap[1] >= 1, "R6 gap after abort", decGap[1], 1);
    twoFlags = 0;
  endtask

  task automatic testLineGaps();
    fillPlain(8'h10, 6, 8'h20, 1);
    bufA[2] = 8'h7E;
    startCap();
    reqToggle = 1;
    txBuf = bufA; txLen = lenA; holeAt = -1; pushFrame();
    stopCap();
    reqToggle = 0;
    check(cap.size() == reqCount, "R8 bytes match requests", cap.size(), reqCount);
    check(nFrames == 1, "R8 frame count with paced requests", nFrames, 1);
    checkFrame(0, 0, "R8 content with paced requests");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check(lineValid == 0, "R8 no request no byte", lineValid, 0);
    testIdle();
    testEscape();
    testBackToBack(0);
    testBackToBack(1);
    testAbort(0);
    testAbort(1);
    testLineGaps();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule